// File: doc/BRIEF.md
# Cascaded Counter Dataflow Controller

This block is the central sequencer for a hardware-mapped dataflow subgraph whose inputs arrive at unpredictable times. Three receive points each raise a one-cycle valid pulse when their data lands. A node with variable execution time inside the subgraph is started by the sequencer and reports back with a done pulse. The sequencer drives a main send-buffer enable, a side send-buffer enable for a second output on a shorter path, a load enable for a delay register on an internal edge, and the start pulse of the variable-time node.

Timing comes from a chain of down-counters. The receive stages are ordered so that the input with the longest critical path counts first. Each stage holds the difference between its own path length and the next one. A stage counts only once its own input has arrived and the stage ahead of it has expired, so the chain reaches zero at the latest of (arrival time + path length) over all inputs, whatever order the inputs come in. Arrival pulses are kept in sticky flags. When the final stage expires, the block fires the main send enable and resets every counter and flag for the next iteration.

After the receive stages comes one more stage. It waits for the done pulse of the variable-time node and then counts the remaining path to the main send. The two intermediate enables come from equality taps on counter values. All counts and tap values are parameters.

Top module: `dfCascadeCtrl`

## Requirements
- R1: With one arrival on each receive input i (i = 0, 1, 2) in cycle R_i, nodeStart first goes high in cycle max over i of (R_i + D_i), where D_i is the sum of STAGE_CNT[i] through STAGE_CNT[2], and all cycle numbers are counted on the same clock.
- R2: A receive stage does not begin counting before its own input has arrived, even if every stage ahead of it has already expired.
- R3: A single-cycle arrival pulse is remembered, so an input that arrives while an earlier stage is still waiting or counting is not lost.
- R4: A further pulse on a receive input that has already arrived in the current iteration has no effect on any output timing.
- R5: sendMainEn is a single-cycle pulse in cycle S + L + STAGE_CNT[3], where S is the nodeStart cycle and L is the number of cycles between nodeStart and the accepted done pulse. In that same cycle all counters reload and all flags clear, so the next iteration starts fresh.
- R6: sendSideEn is a single-cycle pulse exactly SIDE_TAP cycles before sendMainEn.
- R7: delayRegEn is a single-cycle pulse exactly DLY_TAP cycles before stage DLY_STAGE expires. With DLY_STAGE = 2 that is DLY_TAP cycles before nodeStart.
- R8: nodeStart is a single-cycle pulse, issued once per iteration in the first cycle in which all three receive stages have expired. nodeDone is accepted only in cycles after that pulse, so a done pulse before it or in the same cycle is ignored.
- R9: A receive pulse that coincides with the sendMainEn cycle is kept for the next iteration and counts as if it had arrived in the following cycle.
- R10: While rst is high (sampled on the clock), all outputs are low. After reset, all counters hold their initial values and no arrival is remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rcvPulse | input | 3 | One-cycle arrival pulses; bit 0 is the input with the longest critical path, bit 2 the shortest |
| nodeDone | input | 1 | Done pulse from the variable-time node |
| nodeStart | output | 1 | Start pulse to the variable-time node |
| delayRegEn | output | 1 | Load enable for the internal delay register |
| sendSideEn | output | 1 | Enable for the shorter-path send buffer |
| sendMainEn | output | 1 | Enable for the main send buffer; also marks the end of the iteration |

## Verification
The bench builds the block with stage counts 3, 2, 6 and 4, a side tap of 2 and a delay tap of 3 on stage 2. Short counts keep each iteration to a few dozen cycles, so many arrival orders fit in one run: in order, reversed, simultaneous, and a single late input. Small taps place the intermediate enables a few cycles from stage boundaries, where an off-by-one error would show. The bench also covers duplicate and premature pulses, a done pulse in the same cycle as the start pulse, an arrival in the end-of-iteration cycle, and a reset in the middle of an iteration.

// File: rtl/cascPkg.sv
package cascPkg;
  localparam int NUM_RCV    = 3;
  localparam int NUM_STAGES = NUM_RCV + 1;

  typedef struct packed {
    logic [NUM_STAGES-1:0] stageRun;
    logic                  iterClear;
  } ctrlStrobes_t;
endpackage

// File: rtl/cascCountChain.sv
module cascCountChain
  import cascPkg::*;
#(
  parameter int unsigned STAGE_CNT [NUM_STAGES] = '{10, 10, 40, 8},
  parameter int unsigned SIDE_TAP  = 5,
  parameter int unsigned DLY_STAGE = 2,
  parameter int unsigned DLY_TAP   = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_STAGES-1:0] stageZero,
  output logic                  sideHit,
  output logic                  delayHit
);
  function automatic int unsigned peakCount();
    int unsigned m = 1;
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (STAGE_CNT[k] > m) m = STAGE_CNT[k];
    end
    return m;
  endfunction

  localparam int CNT_W = $clog2(peakCount() + 1);
  localparam int LAST  = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0][CNT_W-1:0] cntBus;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    localparam logic [CNT_W-1:0] INIT = CNT_W'(STAGE_CNT[k]);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst || strobes.iterClear) begin
        cnt <= INIT;
      end else if (strobes.stageRun[k]) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign cntBus[k]    = cnt;
    assign stageZero[k] = (cnt == '0);

    // R4/R5: an expired stage stays at zero until the iteration clears
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (stageZero[k] && !strobes.iterClear) |=> stageZero[k]);

    if (k > 0) begin : g_order
      // R2: a stage that has left its initial value implies the stage ahead has expired
      p_chain_order_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt != INIT) |-> stageZero[k-1]);
    end
  end

  assign sideHit  = (cntBus[LAST] == CNT_W'(SIDE_TAP));
  assign delayHit = (cntBus[DLY_STAGE] == CNT_W'(DLY_TAP));
endmodule

// File: rtl/cascSequencer.sv
module cascSequencer
  import cascPkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_RCV-1:0]    rcvPulse,
  input  logic                  nodeDone,
  input  logic [NUM_STAGES-1:0] stageZero,
  input  logic                  sideHit,
  input  logic                  delayHit,
  output ctrlStrobes_t          strobes,
  output logic                  nodeStart,
  output logic                  delayRegEn,
  output logic                  sendSideEn,
  output logic                  sendMainEn
);
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] validFlag;
  logic [NUM_STAGES-1:0] arrival;
  logic [NUM_STAGES-1:0] liveValid;
  logic [NUM_STAGES-1:0] chainGate;
  logic                  startSent;
  logic                  iterEnd;

  assign arrival   = {nodeDone & startSent, rcvPulse};
  assign liveValid = validFlag | arrival;
  assign chainGate = {stageZero[NUM_STAGES-2:0], 1'b1};
  assign iterEnd   = stageZero[LAST];

  always_comb begin
    strobes.iterClear = iterEnd;
    strobes.stageRun  = liveValid & chainGate & ~stageZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validFlag <= '0;
    end else begin
      validFlag <= arrival | (validFlag & ~{NUM_STAGES{iterEnd}});
    end
  end

  assign nodeStart = stageZero[NUM_RCV-1] & ~startSent;

  always_ff @(posedge clk) begin
    if (rst || iterEnd) begin
      startSent <= 1'b0;
    end else if (nodeStart) begin
      startSent <= 1'b1;
    end
  end

  assign sendMainEn = iterEnd;
  assign sendSideEn = sideHit;
  assign delayRegEn = delayHit;

  // R5: the main enable lasts a single cycle
  p_main_single_r5: assert property (@(posedge clk) disable iff (rst)
    sendMainEn |=> !sendMainEn);

  // R5: end of iteration leaves no remembered arrival when none is pending
  p_clear_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (sendMainEn && rcvPulse == '0 && !nodeDone) |=> (validFlag == '0 && !startSent));

  // R8: the done stage is only armed after the start pulse went out
  p_done_gated_r8: assert property (@(posedge clk) disable iff (rst)
    validFlag[LAST] |-> startSent);

  // R8: one start pulse per iteration
  p_start_single_r8: assert property (@(posedge clk) disable iff (rst)
    nodeStart |=> !nodeStart);

  // R6: side enable always precedes the main enable
  p_side_before_main_r6: assert property (@(posedge clk) disable iff (rst)
    sendSideEn |=> !sendMainEn);
endmodule

// File: rtl/dfCascadeCtrl.sv
module dfCascadeCtrl
  import cascPkg::*;
#(
  parameter int unsigned STAGE_CNT [NUM_STAGES] = '{10, 10, 40, 8},
  parameter int unsigned SIDE_TAP  = 5,
  parameter int unsigned DLY_STAGE = 2,
  parameter int unsigned DLY_TAP   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_RCV-1:0] rcvPulse,
  input  logic               nodeDone,
  output logic               nodeStart,
  output logic               delayRegEn,
  output logic               sendSideEn,
  output logic               sendMainEn
);
  ctrlStrobes_t          strobes;
  logic [NUM_STAGES-1:0] stageZero;
  logic                  sideHit;
  logic                  delayHit;

  cascSequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .rcvPulse   (rcvPulse),
    .nodeDone   (nodeDone),
    .stageZero  (stageZero),
    .sideHit    (sideHit),
    .delayHit   (delayHit),
    .strobes    (strobes),
    .nodeStart  (nodeStart),
    .delayRegEn (delayRegEn),
    .sendSideEn (sendSideEn),
    .sendMainEn (sendMainEn)
  );

  cascCountChain #(
    .STAGE_CNT (STAGE_CNT),
    .SIDE_TAP  (SIDE_TAP),
    .DLY_STAGE (DLY_STAGE),
    .DLY_TAP   (DLY_TAP)
  ) u_chain (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .stageZero (stageZero),
    .sideHit   (sideHit),
    .delayHit  (delayHit)
  );
endmodule

// File: tb/tb_dfCascadeCtrl.sv
module tb_dfCascadeCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int N0 = 3, N1 = 2, N2 = 6, N3 = 4;
  localparam int SIDE = 2, DLYT = 3;
  localparam int ITER_LIMIT = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rcvPulse = '0;
  logic       nodeDone = 1'b0;
  logic       nodeStart, delayRegEn, sendSideEn, sendMainEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfCascadeCtrl #(
    .STAGE_CNT ('{N0, N1, N2, N3}),
    .SIDE_TAP  (SIDE),
    .DLY_STAGE (2),
    .DLY_TAP   (DLYT)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .rcvPulse   (rcvPulse),
    .nodeDone   (nodeDone),
    .nodeStart  (nodeStart),
    .delayRegEn (delayRegEn),
    .sendSideEn (sendSideEn),
    .sendMainEn (sendMainEn)
  );

  task automatic check(input bit ok, input string req, input string tag,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, tag, actual, expected);
    end
  endtask

  function automatic int expStart(input int r0, input int r1, input int r2);
    int m = r0 + N0 + N1 + N2;
    if (r1 + N1 + N2 > m) m = r1 + N1 + N2;
    if (r2 + N2 > m) m = r2 + N2;
    return m;
  endfunction

  // one iteration; arrival cycles relative to its first cycle, r0 < 0 means carried in
  task automatic runIter(input string tag, input string startReq,
                         input int r0, input int r1, input int r2,
                         input int dup0, input int earlyDone, input int doneLat,
                         input bit echoDone, input bit carry);
    int r0e = (r0 < 0) ? 0 : r0;
    int eS = expStart(r0e, r1, r2);
    int eMain = eS + doneLat + N3;
    int fS = -1, fD = -1, fSide = -1, fMain = -1;
    int nS = 0, nMain = 0;
    int k = 0;
    bit over = 0;
    while (!over && k < ITER_LIMIT) begin
      @(negedge clk);
      if (nodeStart)  begin nS++;    if (fS < 0) fS = k; end
      if (delayRegEn && fD < 0)    fD = k;
      if (sendSideEn && fSide < 0) fSide = k;
      if (sendMainEn) begin nMain++; if (fMain < 0) fMain = k; end
      rcvPulse[0] = (k == r0) || (k == dup0);
      rcvPulse[1] = (k == r1);
      rcvPulse[2] = (k == r2);
      nodeDone = (k == earlyDone) ||
                 (fS >= 0 && ((k == fS + doneLat) || (echoDone && k == fS)));
      if (sendMainEn) begin
        over = 1;
        rcvPulse = carry ? 3'b001 : 3'b000;
        nodeDone = 1'b0;
      end
      k++;
    end
    check(fS == eS, startReq, tag, fS, eS);
    check(fD == eS - DLYT, "R7", tag, fD, eS - DLYT);
    check(fSide == eMain - SIDE, "R6", tag, fSide, eMain - SIDE);
    check(fMain == eMain, "R5", tag, fMain, eMain);
    check(nS == 1, "R8", tag, nS, 1);
    check(nMain == 1, "R5", tag, nMain, 1);
  endtask

  task automatic testReset();
    rst = 1'b1;
    rcvPulse = 3'b111;
    repeat (3) @(negedge clk);
    check({nodeStart, delayRegEn, sendSideEn, sendMainEn} == 4'b0, "R10", "reset outputs",
          {nodeStart, delayRegEn, sendSideEn, sendMainEn}, 0);
    rcvPulse = '0;
    rst = 1'b0;
  endtask

  task automatic testMidReset();
    @(negedge clk); rcvPulse = 3'b001;
    @(negedge clk); rcvPulse = 3'b010;
    @(negedge clk); rcvPulse = '0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check({nodeStart, delayRegEn, sendSideEn, sendMainEn} == 4'b0, "R10", "mid reset",
          {nodeStart, delayRegEn, sendSideEn, sendMainEn}, 0);
    rst = 1'b0;
    // r10_ fresh state: stage 0 must wait for its own late arrival
    runIter("after reset", "R10", 6, 0, 0, -1, -1, 2, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    runIter("in order", "R1", 0, 5, 12, -1, -1, 3, 0, 0);
    runIter("reversed", "R3", 20, 3, 0, -1, -1, 1, 0, 0);
    runIter("together", "R1", 0, 0, 0, -1, -1, 5, 0, 0);
    runIter("late middle", "R2", 0, 30, 0, -1, -1, 2, 0, 0);
    runIter("duplicate rcv0", "R4", 2, 4, 6, 7, -1, 3, 0, 0);
    runIter("early done", "R8", 2, 4, 6, -1, 1, 5, 0, 0);
    runIter("done with start", "R8", 1, 1, 1, -1, -1, 3, 1, 0);
    runIter("carry out", "R1", 0, 1, 2, -1, -1, 2, 0, 1);
    runIter("carried in", "R9", -1, 0, 0, -1, -1, 2, 0, 0);
    testMidReset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule